// File: doc/BRIEF.md
# SMI Event Status Register

This block gathers system-management events into one nine-bit status word and drives an active-low SMI request while any latched, enabled event is pending. Hardware sets the sticky bits. Software reads the word through a simple read/write port and clears the sticky bits by writing a 1 to them. The sources are:

- a watchdog countdown that reached zero
- writes to the inbound and outbound mailboxes
- illegal attempts to write the firmware flash
- the calendar year wrapping into a new century

One further bit reports an NMI that was redirected into an SMI. It follows the NMI status and does not respond to writes.

The century flag lives in a slow, always-on clock domain. It is set there when the BCD year value wraps. Clear requests from the main domain cross into that domain as a toggle. The flag's value crosses back through a synchroniser, so a clear takes a few slow clocks to become visible. The watchdog counter, the real-time clock and the address decoding are outside this block: they deliver one-cycle pulses, the year value and the control bits.

Top module: `smi_event_status`

## Requirements
- R1: After main reset, `reg_rdata` reads 0, `smi_n` is 1 and `wake_req` is 0.
- R2: A one-cycle pulse sets a status bit that reads back 1 after the next `clk` edge:
  - `wdt_zero` sets bit 3
  - `mbox_in_wr` sets bit 1
  - `mbox_out_wr` sets bit 2
- R3: When `reg_wr` is high, a 1 in `reg_wdata` at bit 8, 3, 2 or 1 clears that bit at the next edge. A 0 at those positions leaves the bit unchanged.
- R4: If a set event and a clearing write hit the same bit in the same cycle, the bit stays 1.
- R5: Bit 8 sets when `wp_en` goes from 0 to 1 (compared with its value at the previous edge) while `lock_down` is 1. A 0-to-1 change with `lock_down` at 0 does not set it.
- R6: Bit 8 sets when `fw_wr` is high while `wp_en` is 1, unless `fw_low_alias` is also high.
- R7: Bit 7 sets when two consecutive `rtc_clk` samples of `rtc_year` are 8'h99 and then 8'h00. No other pair of values sets it. The flag reaches `reg_rdata` within one slow clock plus the synchroniser delay.
- R8: A write of 1 to bit 7 clears the century flag no sooner than the second and no later than the third `rtc_clk` edge after the write. The cleared value then appears on `reg_rdata` after the synchroniser delay. Holding `rtc_rst_n` low also clears the flag.
- R9: Bit 0 becomes 1 one edge after `nmi_sts` and `nmi_redir_en` are both 1. It stays 1 while `nmi_sts` stays 1, even if `nmi_redir_en` drops. It clears at the edge after `nmi_sts` goes to 0.
- R10: Writes have no effect on bits 6:4, which always read 0, or on bit 0.
- R11: `smi_n` is 0 exactly when some status bit is 1 and the matching bit of `smi_en` is 1.
- R12: `wake_req` is 1 exactly when bit 7 or bit 3 is set with its `smi_en` bit. Bit 8 never raises `wake_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Main asynchronous reset, active low |
| rtc_clk | input | 1 | Slow always-on clock |
| rtc_rst_n | input | 1 | Always-on domain reset, active low; clears the century flag |
| rtc_year | input | 8 | BCD year value, in the `rtc_clk` domain |
| wdt_zero | input | 1 | Pulse: watchdog countdown reached zero |
| mbox_in_wr | input | 1 | Pulse: inbound mailbox written |
| mbox_out_wr | input | 1 | Pulse: outbound mailbox written |
| wp_en | input | 1 | Firmware write-protect control level |
| lock_down | input | 1 | Lock-down control level |
| fw_wr | input | 1 | Pulse: write decoded to firmware space |
| fw_low_alias | input | 1 | Qualifies `fw_wr` as targeting the lower alias |
| nmi_sts | input | 1 | NMI status level |
| nmi_redir_en | input | 1 | NMI-to-SMI redirect enable |
| smi_en | input | 9 | Per-bit enable for `smi_n` and `wake_req` |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 9 | Register write data (write-1-to-clear) |
| reg_rdata | output | 9 | Current status word |
| smi_n | output | 1 | SMI request, active low |
| wake_req | output | 1 | Wake request |

## Verification
The bench targets several corner cases:

- A set pulse that arrives in the same cycle as a clearing write. A design where the clear wins would lose the event.
- A write-protect rise with and without lock-down, and firmware writes with and without the alias flag. Swapping either qualifier would raise spurious SMIs or miss real violations.
- The NMI bit, which must outlive a dropped redirect enable and still ignore writes.
- The century flag, which is checked against both ends of its clear window. A missing synchroniser would show the clear too early, a lost toggle would never clear, and a wrap detector that ignores the previous year sample would set on any year of 00.

// File: rtl/smi_sts_pkg.sv
package smi_sts_pkg;

    localparam int STS_W    = 9;
    localparam int YEAR_W   = 8;

    localparam int BIT_NMI  = 0;
    localparam int BIT_SW   = 1;
    localparam int BIT_INTR = 2;
    localparam int BIT_TMO  = 3;
    localparam int BIT_CEN  = 7;
    localparam int BIT_VIOL = 8;

    localparam logic [YEAR_W-1:0] YEAR_LAST  = 8'h99;
    localparam logic [YEAR_W-1:0] YEAR_FIRST = 8'h00;

    typedef struct packed {
        logic viol;
        logic tmo;
        logic intr;
        logic swsmi;
        logic nmi;
        logic wp_prev;
        logic clr_tgl;
    } core_state_t;

    typedef struct packed {
        logic [YEAR_W-1:0] year_prev;
        logic              cen;
        logic              tgl_seen;
    } cen_state_t;

endpackage

// File: rtl/smi_bit_sync.sv
module smi_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sync_d, sync_q;

    always_comb begin
        sync_d = {sync_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];

endmodule

// File: rtl/smi_century_cell.sv
module smi_century_cell
    import smi_sts_pkg::*;
(
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic [YEAR_W-1:0] year,
    input  logic              clr_tgl_sync,
    output logic              cen
);

    cen_state_t st_d, st_q;
    logic       wrap;
    logic       clr_req;

    always_comb begin
        st_d         = st_q;
        wrap         = (st_q.year_prev == YEAR_LAST) && (year == YEAR_FIRST);
        clr_req      = clr_tgl_sync ^ st_q.tgl_seen;
        st_d.year_prev = year;
        st_d.tgl_seen  = clr_tgl_sync;
        st_d.cen       = wrap | (st_q.cen & ~clr_req);
    end

    always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
        if (!rtc_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    assign cen = st_q.cen;

    // R7: a 99 -> 00 step of the year sets the flag
    p_wrap_sets_r7: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        (st_q.year_prev == YEAR_LAST && year == YEAR_FIRST) |=> cen);

    // R8: a seen clear request without a wrap leaves the flag low
    p_clear_takes_r8: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n)
        ((clr_tgl_sync != st_q.tgl_seen) && !(st_q.year_prev == YEAR_LAST && year == YEAR_FIRST)) |=> !cen);

endmodule

// File: rtl/smi_sts_core.sv
module smi_sts_core
    import smi_sts_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_zero,
    input  logic             mbox_in_wr,
    input  logic             mbox_out_wr,
    input  logic             wp_en,
    input  logic             lock_down,
    input  logic             fw_wr,
    input  logic             fw_low_alias,
    input  logic             nmi_sts,
    input  logic             nmi_redir_en,
    input  logic             reg_wr,
    input  logic [STS_W-1:0] reg_wdata,
    output logic             viol,
    output logic             tmo,
    output logic             intr,
    output logic             swsmi,
    output logic             nmi_flag,
    output logic             clr_tgl
);

    core_state_t      st_d, st_q;
    logic [STS_W-1:0] w1c;
    logic             wp_rise_locked;
    logic             prot_write;

    always_comb begin
        st_d           = st_q;
        w1c            = reg_wr ? reg_wdata : '0;
        wp_rise_locked = wp_en & ~st_q.wp_prev & lock_down;
        prot_write     = fw_wr & wp_en & ~fw_low_alias;

        st_d.viol    = wp_rise_locked | prot_write | (st_q.viol  & ~w1c[BIT_VIOL]);
        st_d.tmo     = wdt_zero                     | (st_q.tmo   & ~w1c[BIT_TMO]);
        st_d.intr    = mbox_out_wr                  | (st_q.intr  & ~w1c[BIT_INTR]);
        st_d.swsmi   = mbox_in_wr                   | (st_q.swsmi & ~w1c[BIT_SW]);
        st_d.nmi     = nmi_sts & (st_q.nmi | nmi_redir_en);
        st_d.wp_prev = wp_en;
        st_d.clr_tgl = st_q.clr_tgl ^ w1c[BIT_CEN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign viol     = st_q.viol;
    assign tmo      = st_q.tmo;
    assign intr     = st_q.intr;
    assign swsmi    = st_q.swsmi;
    assign nmi_flag = st_q.nmi;
    assign clr_tgl  = st_q.clr_tgl;

    // R2: watchdog pulse is latched
    p_tmo_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_zero |=> tmo);

    // R3: writing 0 keeps a set bit
    p_w0_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (swsmi && reg_wr && !reg_wdata[BIT_SW]) |=> swsmi);

    // R3: writing 1 clears when no event arrives
    p_w1_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[BIT_INTR] && !mbox_out_wr) |=> !intr);

    // R4: event beats a same-cycle clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_in_wr && reg_wr && reg_wdata[BIT_SW]) |=> swsmi);

    // R6: protected non-alias write traps
    p_prot_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fw_wr && wp_en && !fw_low_alias) |=> viol);

    // R9: NMI bit drops with the NMI status
    p_nmi_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_sts |=> !nmi_flag);

    // R9: NMI bit holds while status persists
    p_nmi_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_flag && nmi_sts) |=> nmi_flag);

endmodule

// File: rtl/smi_event_status.sv
module smi_event_status
    import smi_sts_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_clk,
    input  logic              rtc_rst_n,
    input  logic [YEAR_W-1:0] rtc_year,
    input  logic              wdt_zero,
    input  logic              mbox_in_wr,
    input  logic              mbox_out_wr,
    input  logic              wp_en,
    input  logic              lock_down,
    input  logic              fw_wr,
    input  logic              fw_low_alias,
    input  logic              nmi_sts,
    input  logic              nmi_redir_en,
    input  logic [STS_W-1:0]  smi_en,
    input  logic              reg_wr,
    input  logic [STS_W-1:0]  reg_wdata,
    output logic [STS_W-1:0]  reg_rdata,
    output logic              smi_n,
    output logic              wake_req
);

    logic             viol, tmo, intr, swsmi, nmi_flag, clr_tgl;
    logic             clr_tgl_rtc, cen_rtc, cen_main;
    logic [STS_W-1:0] sts;

    smi_sts_core u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wdt_zero     (wdt_zero),
        .mbox_in_wr   (mbox_in_wr),
        .mbox_out_wr  (mbox_out_wr),
        .wp_en        (wp_en),
        .lock_down    (lock_down),
        .fw_wr        (fw_wr),
        .fw_low_alias (fw_low_alias),
        .nmi_sts      (nmi_sts),
        .nmi_redir_en (nmi_redir_en),
        .reg_wr       (reg_wr),
        .reg_wdata    (reg_wdata),
        .viol         (viol),
        .tmo          (tmo),
        .intr         (intr),
        .swsmi        (swsmi),
        .nmi_flag     (nmi_flag),
        .clr_tgl      (clr_tgl)
    );

    smi_bit_sync #(.STAGES(SYNC_STAGES)) u_clr_to_rtc (
        .clk   (rtc_clk),
        .rst_n (rtc_rst_n),
        .din   (clr_tgl),
        .dout  (clr_tgl_rtc)
    );

    smi_century_cell u_cen (
        .rtc_clk      (rtc_clk),
        .rtc_rst_n    (rtc_rst_n),
        .year         (rtc_year),
        .clr_tgl_sync (clr_tgl_rtc),
        .cen          (cen_rtc)
    );

    smi_bit_sync #(.STAGES(SYNC_STAGES)) u_cen_to_main (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (cen_rtc),
        .dout  (cen_main)
    );

    always_comb begin
        sts           = '0;
        sts[BIT_VIOL] = viol;
        sts[BIT_CEN]  = cen_main;
        sts[BIT_TMO]  = tmo;
        sts[BIT_INTR] = intr;
        sts[BIT_SW]   = swsmi;
        sts[BIT_NMI]  = nmi_flag;
    end

    assign reg_rdata = sts;
    assign smi_n     = ~|(sts & smi_en);
    assign wake_req  = (sts[BIT_CEN] & smi_en[BIT_CEN]) | (sts[BIT_TMO] & smi_en[BIT_TMO]);

    // R12: a wake needs the century or timeout bit
    p_wake_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (reg_rdata[BIT_CEN] || reg_rdata[BIT_TMO]));

    // R11: any wake request also asserts the SMI
    p_wake_implies_smi_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> !smi_n);

endmodule

// File: tb/test_smi_event_status.sv
module test_smi_event_status;

    localparam int CLK_PERIOD = 10;
    localparam int RTC_PERIOD = 40;

    logic       clk = 0, rtc_clk = 0;
    logic       rst_n = 0, rtc_rst_n = 0;
    logic [7:0] rtc_year = 8'h00;
    logic       wdt_zero = 0, mbox_in_wr = 0, mbox_out_wr = 0;
    logic       wp_en = 0, lock_down = 0, fw_wr = 0, fw_low_alias = 0;
    logic       nmi_sts = 0, nmi_redir_en = 0;
    logic [8:0] smi_en = 9'h1FF;
    logic       reg_wr = 0;
    logic [8:0] reg_wdata = 0;
    logic [8:0] reg_rdata;
    logic       smi_n, wake_req;

    int checks = 0, errors = 0, cycles = 0;
    bit done = 0;

    // behavioural model of the main-domain bits
    bit m_viol, m_tmo, m_intr, m_sw, m_nmi, m_wp_prev;

    smi_event_status i_smi_event_status (
        .clk(clk), .rst_n(rst_n), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
        .rtc_year(rtc_year), .wdt_zero(wdt_zero), .mbox_in_wr(mbox_in_wr),
        .mbox_out_wr(mbox_out_wr), .wp_en(wp_en), .lock_down(lock_down),
        .fw_wr(fw_wr), .fw_low_alias(fw_low_alias), .nmi_sts(nmi_sts),
        .nmi_redir_en(nmi_redir_en), .smi_en(smi_en), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_n(smi_n),
        .wake_req(wake_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always #(RTC_PERIOD/2) rtc_clk = ~rtc_clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] model_vec();
        logic [8:0] v = '0;
        v[8] = m_viol; v[3] = m_tmo; v[2] = m_intr; v[1] = m_sw; v[0] = m_nmi;
        return v;
    endfunction

    task automatic model_step();
        bit w8, w3, w2, w1, vs;
        if (!rst_n) begin
            {m_viol, m_tmo, m_intr, m_sw, m_nmi, m_wp_prev} = '0;
            return;
        end
        w8 = reg_wr && reg_wdata[8]; w3 = reg_wr && reg_wdata[3];
        w2 = reg_wr && reg_wdata[2]; w1 = reg_wr && reg_wdata[1];
        vs = (wp_en && !m_wp_prev && lock_down) || (fw_wr && wp_en && !fw_low_alias);
        m_viol = vs || (m_viol && !w8);
        m_tmo  = wdt_zero || (m_tmo && !w3);
        m_intr = mbox_out_wr || (m_intr && !w2);
        m_sw   = mbox_in_wr || (m_sw && !w1);
        m_nmi  = nmi_sts && (m_nmi || nmi_redir_en);
        m_wp_prev = wp_en;
    endtask

    // one clock: model advances with the design, outputs compared after settling
    task automatic tick();
        logic [8:0] full;
        @(posedge clk);
        model_step();
        #2;
        full = model_vec();
        full[7] = reg_rdata[7];
        chk("R2 R3 R5 R6 R9 R10 model", {23'b0, reg_rdata & 9'h17F}, {23'b0, model_vec()});
        chk("R11 smi_n model", {31'b0, smi_n}, {31'b0, ~|(full & smi_en)});
        chk("R12 wake model", {31'b0, wake_req},
            {31'b0, (full[7] & smi_en[7]) | (full[3] & smi_en[3])});
    endtask

    task automatic write_reg(input logic [8:0] d);
        reg_wr = 1; reg_wdata = d;
        tick();
        reg_wr = 0; reg_wdata = 0;
    endtask

    task automatic wait_bit7(input logic val, input int limit, output int took);
        took = 0;
        while (reg_rdata[7] !== val && took < limit) begin
            tick();
            took++;
        end
    endtask

    initial begin
        int took;
        repeat (3) tick();
        rst_n = 1; rtc_rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 rdata", {23'b0, reg_rdata}, 0);
        chk("R1 smi_n", {31'b0, smi_n}, 1);
        chk("R1 wake", {31'b0, wake_req}, 0);

        // R2 event pulses
        wdt_zero = 1; tick(); wdt_zero = 0;
        chk("R2 timeout bit", {31'b0, reg_rdata[3]}, 1);
        chk("R12 timeout wakes", {31'b0, wake_req}, 1);
        mbox_in_wr = 1; tick(); mbox_in_wr = 0;
        chk("R2 sw bit", {31'b0, reg_rdata[1]}, 1);
        mbox_out_wr = 1; tick(); mbox_out_wr = 0;
        chk("R2 intr bit", {31'b0, reg_rdata[2]}, 1);

        // R3 write 0 keeps, write 1 clears
        write_reg(9'h000);
        chk("R3 write0 keeps", {23'b0, reg_rdata}, 9'h00E);
        write_reg(9'h008);
        chk("R3 write1 clears bit3", {23'b0, reg_rdata}, 9'h006);

        // R4 set wins against a same-cycle clear
        mbox_in_wr = 1; write_reg(9'h006); mbox_in_wr = 0;
        chk("R4 set wins", {23'b0, reg_rdata}, 9'h002);
        write_reg(9'h002);
        chk("R3 cleared", {23'b0, reg_rdata}, 0);

        // R5 write-protect rise with and without lock-down
        wp_en = 1; tick();
        chk("R5 rise unlocked", {31'b0, reg_rdata[8]}, 0);
        wp_en = 0; lock_down = 1; tick();
        wp_en = 1; tick();
        chk("R5 rise locked", {31'b0, reg_rdata[8]}, 1);
        chk("R12 violation no wake", {31'b0, wake_req}, 0);
        chk("R11 violation smi", {31'b0, smi_n}, 0);
        tick();
        write_reg(9'h100);
        chk("R5 held level no retrap", {31'b0, reg_rdata[8]}, 0);

        // R6 firmware writes and the alias qualifier
        fw_wr = 1; fw_low_alias = 1; tick(); fw_wr = 0; fw_low_alias = 0;
        chk("R6 alias ignored", {31'b0, reg_rdata[8]}, 0);
        fw_wr = 1; tick(); fw_wr = 0;
        chk("R6 protected write", {31'b0, reg_rdata[8]}, 1);
        write_reg(9'h100);
        wp_en = 0; lock_down = 0;
        fw_wr = 1; tick(); fw_wr = 0;
        chk("R6 unprotected write", {31'b0, reg_rdata[8]}, 0);

        // R9 / R10 NMI redirect bit
        nmi_sts = 1; tick();
        chk("R9 no redirect", {31'b0, reg_rdata[0]}, 0);
        nmi_redir_en = 1; tick();
        chk("R9 redirected", {31'b0, reg_rdata[0]}, 1);
        nmi_redir_en = 0; tick();
        chk("R9 holds after enable drops", {31'b0, reg_rdata[0]}, 1);
        write_reg(9'h001);
        chk("R10 bit0 ignores write", {31'b0, reg_rdata[0]}, 1);
        nmi_sts = 0; tick();
        chk("R9 clears with status", {31'b0, reg_rdata[0]}, 0);

        // R10 reserved bits
        write_reg(9'h070);
        chk("R10 reserved zero", {29'b0, reg_rdata[6:4]}, 0);

        // R11 enable mask
        mbox_out_wr = 1; tick(); mbox_out_wr = 0;
        smi_en = 9'h1FB; #1;
        chk("R11 masked", {31'b0, smi_n}, 1);
        smi_en = 9'h004; #1;
        chk("R11 enabled", {31'b0, smi_n}, 0);
        smi_en = 9'h1FF;
        write_reg(9'h004);

        // R7 century wrap detection
        rtc_year = 8'h59; repeat (12) tick();
        rtc_year = 8'h00; repeat (12) tick();
        chk("R7 non-99 to 00", {31'b0, reg_rdata[7]}, 0);
        rtc_year = 8'h99; repeat (12) tick();
        chk("R7 at 99", {31'b0, reg_rdata[7]}, 0);
        rtc_year = 8'h00;
        wait_bit7(1'b1, 10, took);
        chk("R7 wrap sets", {31'b0, reg_rdata[7]}, 1);
        chk("R12 century wakes", {31'b0, wake_req}, 1);
        repeat (8) tick();
        chk("R7 stays after wrap", {31'b0, reg_rdata[7]}, 1);

        // R8 cross-domain clear window
        write_reg(9'h080);
        tick();
        chk("R8 not cleared at once", {31'b0, reg_rdata[7]}, 1);
        wait_bit7(1'b0, 16, took);
        chk("R8 cleared in window", {31'b0, reg_rdata[7]}, 0);
        repeat (12) tick();
        chk("R8 stays cleared", {31'b0, reg_rdata[7]}, 0);

        // R8 slow-domain reset clears
        rtc_year = 8'h99; repeat (12) tick();
        rtc_year = 8'h00;
        wait_bit7(1'b1, 10, took);
        chk("R7 second wrap", {31'b0, reg_rdata[7]}, 1);
        #3 rtc_rst_n = 0;
        repeat (8) tick();
        rtc_rst_n = 1;
        repeat (4) tick();
        chk("R8 rtc reset clears", {31'b0, reg_rdata[7]}, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule